// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a queue of byte-oriented frames into one synchronous serial line, one bit per clock. Each frame arrives as a run of bytes on a valid/ready stream whose last byte carries an end marker. The block puts an opening flag on the line, sends the payload, appends a frame check sequence computed over that payload, and sends a closing flag. Between the two flags it inserts a zero after every run of five ones, so that no flag pattern appears inside a frame.

When the next frame is already offered as a frame closes, that closing flag also opens the new frame. With no frame pending the line carries idle fill: repeated flags or constant ones, chosen by a mode pin. A frame in progress can be cut short with an abort request. A frame whose next byte is missing at a byte boundary is also aborted, because a serial line cannot pause in the middle of a frame.

Stream rules: a byte moves when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` does not depend on `in_valid`. It rises for a single cycle, only when the line needs the first bit of a new payload byte. It stays low during flags, idle fill, stuffed zeros, FCS bits and abort bits. The upstream must hold a byte stable until it is accepted. After an abort, the upstream drops the rest of that frame.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Each frame is opened and closed by the flag 0x7E, sent least significant bit first, so the bit sequence on the line is 0,1,1,1,1,1,1,0.
- R2: Payload bytes are sent least significant bit first, in the order accepted. One byte moves per handshake, and the byte with `in_last` high is the last payload byte of its frame.
- R3: Between the flags, a 0 is inserted after every five consecutive 1 bits of payload or FCS, including at the boundary into the closing flag. A receiver that removes these zeros recovers the payload and FCS exactly.
- R4: With `USE_CRC32`=0 the FCS is 16 bits wide. It uses the reflected CCITT polynomial 0x8408 with the register preset to all ones, and is sent complemented, low-order bit first. For the ASCII payload "123456789" the FCS value is 0x906E, sent as bytes 0x6E then 0x90.
- R5: With `USE_CRC32`=1 the FCS is 32 bits wide. It uses the reflected polynomial 0xEDB88320, preset to all ones, and is sent complemented, low-order bit first. For "123456789" the value is 0xCBF43926.
- R6: If a new frame is offered (`in_valid` high) when the closing flag ends, its payload follows that flag directly, with no second flag in between.
- R7: With no frame pending, the line carries back-to-back flags when `idle_flags`=1 and constant 1 bits when `idle_flags`=0.
- R8: `abort_req` high while payload or FCS is being sent ends the frame. The block sends at least seven consecutive 1 bits without stuffing, sends neither FCS nor closing flag, and then returns to idle fill.
- R9: If `in_valid` is low when the next payload byte is due, the frame is aborted as in R8.
- R10: `in_ready` is never high in two consecutive cycles, and it is low in idle fill.
- R11: During reset `tx_bit` is 1 and `in_ready` is 0. The first bit after reset starts idle fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a payload byte |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte ends its frame |
| in_ready | output | 1 | Byte is taken at this edge if valid |
| abort_req | input | 1 | Terminate the frame in progress |
| idle_flags | input | 1 | Idle fill: 1 = flags, 0 = all ones |
| tx_bit | output | 1 | Serial line output, registered |

## Verification
The assertions check four rules on every cycle: no more than five ones in a row leave the block while payload or FCS is being sent, every abort bit and every all-ones idle bit is a 1, and `in_ready` never stays high for two cycles. Whether the frame on the line is correct can only be shown by the bench scenarios. These decode the captured line with an independent receiver that hunts for flags and removes stuffed zeros. The bench then compares payloads and FCS values, checks that a closing flag was shared, and checks that aborted or underrun frames never appear as complete frames.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  // Units on the line (flags, idle fill, payload bytes, abort run) are 8 bits.
  localparam int UNIT_BITS = 8;
  localparam int POS_W     = $clog2(UNIT_BITS);

  // Flag octet; its bit pattern is symmetric, so LSB-first order reads the same.
  localparam logic [UNIT_BITS-1:0] FLAG_OCTET = 8'h7E;

  // Longest run of ones allowed inside a frame before a zero is inserted.
  localparam int RUN_LIMIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

endpackage

// File: rtl/hdlc_fcs_gen.sv
// Bit-serial reflected CRC register; one payload bit is folded in per enable.
module hdlc_fcs_gen #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  POLY = 16'h8408
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc_q
);

  logic         fb;
  logic [W-1:0] crc_next;

  always_comb begin
    fb       = crc_q[0] ^ din;
    crc_next = {1'b0, crc_q[W-1:1]} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (init) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= crc_next;
    end
  end

endmodule

// File: rtl/hdlc_stuff_ctr.sv
// Counts consecutive ones in the stuffable part of the stream.
module hdlc_stuff_ctr #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic line_bit,
  output logic stuff_due
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr || !line_bit) begin
      run_q <= '0;
    end else if (run_q != CW'(RUN)) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign stuff_due = (run_q == CW'(RUN));

endmodule

// File: rtl/hdlc_tx_seq.sv
// Frame sequencer: picks the next line bit and registers it.
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int FCS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             abort_req,
  input  logic             idle_flags,
  input  logic             stuff_due,
  input  logic [FCS_W-1:0] crc_q,
  output logic             crc_init,
  output logic             crc_en,
  output logic             line_bit,
  output logic             run_clr,
  output logic             tx_bit,
  output tx_state_e        st_o
);

  localparam int IDX_W = $clog2(FCS_W);
  localparam logic [POS_W-1:0] POS_END = POS_W'(UNIT_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FCS_W - 1);

  tx_state_e            st_q, st_n;
  logic [POS_W-1:0]     pos_q, pos_n;
  logic [UNIT_BITS-1:0] sh_q, sh_n;
  logic                 last_q, last_n;
  logic [IDX_W-1:0]     fidx_q, fidx_n;
  logic                 bit_n;
  logic                 stuffable;
  logic                 data_bit;
  logic                 rdy;

  always_comb begin
    st_n      = st_q;
    pos_n     = pos_q;
    sh_n      = sh_q;
    last_n    = last_q;
    fidx_n    = fidx_q;
    bit_n     = 1'b1;
    stuffable = 1'b0;
    data_bit  = 1'b0;
    rdy       = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        bit_n = idle_flags ? FLAG_OCTET[pos_q] : 1'b1;
        pos_n = pos_q + 1'b1;
        if (pos_q == POS_END && in_valid) st_n = ST_OPEN;
      end

      ST_OPEN: begin
        bit_n = FLAG_OCTET[pos_q];
        pos_n = pos_q + 1'b1;
        if (pos_q == POS_END) st_n = ST_DATA;
      end

      ST_DATA: begin
        if (abort_req) begin
          st_n  = ST_ABORT;
          pos_n = '0;
          bit_n = 1'b1;
        end else if (stuff_due) begin
          bit_n     = 1'b0;
          stuffable = 1'b1;
        end else if (pos_q == '0) begin
          rdy = 1'b1;
          if (!in_valid) begin
            // Underrun: the line cannot wait, so the frame is aborted.
            st_n  = ST_ABORT;
            pos_n = '0;
            bit_n = 1'b1;
          end else begin
            bit_n     = in_data[0];
            sh_n      = {1'b0, in_data[7:1]};
            last_n    = in_last;
            pos_n     = pos_q + 1'b1;
            data_bit  = 1'b1;
            stuffable = 1'b1;
          end
        end else begin
          bit_n     = sh_q[0];
          sh_n      = {1'b0, sh_q[UNIT_BITS-1:1]};
          pos_n     = pos_q + 1'b1;
          data_bit  = 1'b1;
          stuffable = 1'b1;
          if (pos_q == POS_END && last_q) begin
            st_n   = ST_FCS;
            fidx_n = '0;
          end
        end
      end

      ST_FCS: begin
        if (abort_req) begin
          st_n  = ST_ABORT;
          pos_n = '0;
          bit_n = 1'b1;
        end else if (stuff_due) begin
          bit_n     = 1'b0;
          stuffable = 1'b1;
        end else begin
          bit_n     = ~crc_q[fidx_q];
          stuffable = 1'b1;
          fidx_n    = fidx_q + 1'b1;
          if (fidx_q == IDX_END) begin
            st_n  = ST_CLOSE;
            pos_n = '0;
          end
        end
      end

      ST_CLOSE: begin
        if (pos_q == '0 && stuff_due) begin
          // Last FCS bits ended in five ones: stuff before the flag.
          bit_n     = 1'b0;
          stuffable = 1'b1;
        end else begin
          bit_n = FLAG_OCTET[pos_q];
          pos_n = pos_q + 1'b1;
          if (pos_q == POS_END) st_n = in_valid ? ST_DATA : ST_IDLE;
        end
      end

      ST_ABORT: begin
        bit_n = 1'b1;
        pos_n = pos_q + 1'b1;
        if (pos_q == POS_END) st_n = ST_IDLE;
      end

      default: begin
        st_n  = ST_IDLE;
        pos_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
      fidx_q <= '0;
      tx_bit <= 1'b1;
    end else begin
      st_q   <= st_n;
      pos_q  <= pos_n;
      sh_q   <= sh_n;
      last_q <= last_n;
      fidx_q <= fidx_n;
      tx_bit <= bit_n;
    end
  end

  assign in_ready = rdy;
  assign crc_en   = data_bit;
  assign crc_init = (st_q != ST_DATA) && (st_q != ST_FCS);
  assign line_bit = bit_n;
  assign run_clr  = !stuffable;
  assign st_o     = st_q;

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter bit USE_CRC32 = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       abort_req,
  input  logic       idle_flags,
  output logic       tx_bit
);

  localparam int FCS_W = USE_CRC32 ? 32 : 16;

  logic             crc_init;
  logic             crc_en;
  logic             line_bit;
  logic             run_clr;
  logic             stuff_due;
  logic [FCS_W-1:0] crc_q;
  tx_state_e        st_w;

  hdlc_tx_seq #(.FCS_W(FCS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .abort_req  (abort_req),
    .idle_flags (idle_flags),
    .stuff_due  (stuff_due),
    .crc_q      (crc_q),
    .crc_init   (crc_init),
    .crc_en     (crc_en),
    .line_bit   (line_bit),
    .run_clr    (run_clr),
    .tx_bit     (tx_bit),
    .st_o       (st_w)
  );

  hdlc_stuff_ctr #(.RUN(RUN_LIMIT)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (run_clr),
    .line_bit  (line_bit),
    .stuff_due (stuff_due)
  );

  if (USE_CRC32) begin : g_fcs32
    hdlc_fcs_gen #(.W(32), .POLY(32'hEDB88320)) u_fcs (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .en    (crc_en),
      .din   (line_bit),
      .crc_q (crc_q)
    );
  end else begin : g_fcs16
    hdlc_fcs_gen #(.W(16), .POLY(16'h8408)) u_fcs (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .en    (crc_en),
      .din   (line_bit),
      .crc_q (crc_q)
    );
  end

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
  import hdlc_tx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      in_ready,
  input logic      idle_flags,
  input logic      tx_bit,
  input tx_state_e st
);

  // st_d is the state that produced the current tx_bit.
  tx_state_e  st_d;
  logic       idle_d;
  logic [2:0] run_q;
  logic [2:0] run_now;

  always_comb run_now = tx_bit ? ((run_q == 3'd7) ? 3'd7 : run_q + 3'd1) : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d   <= ST_IDLE;
      idle_d <= 1'b1;
      run_q  <= '0;
    end else begin
      st_d   <= st;
      idle_d <= idle_flags;
      run_q  <= run_now;
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_d == ST_DATA || st_d == ST_FCS) && st != ST_ABORT) |-> (run_now <= 3'd5)); // R3

  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R10

  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_d == ST_ABORT) |-> tx_bit); // R8

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_d == ST_IDLE && !idle_d) |-> tx_bit); // R7

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .idle_flags (idle_flags),
  .tx_bit     (tx_bit),
  .st         (st_w)
);

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0;
  logic [7:0] d = 8'h00;
  logic       l = 1'b0;
  logic       ab = 1'b0;
  logic       idlef = 1'b1;
  logic       sel = 1'b0;
  logic       rdy0, rdy1, tx0, tx1;
  logic       rdy, txs;

  always #10 clk = ~clk;

  hdlc_tx_framer #(.USE_CRC32(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v & ~sel), .in_data(d), .in_last(l),
    .in_ready(rdy0), .abort_req(ab & ~sel), .idle_flags(idlef), .tx_bit(tx0));

  hdlc_tx_framer #(.USE_CRC32(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v & sel), .in_data(d), .in_last(l),
    .in_ready(rdy1), .abort_req(ab & sel), .idle_flags(idlef), .tx_bit(tx1));

  assign rdy = sel ? rdy1 : rdy0;
  assign txs = sel ? tx1 : tx0;

  int nchk = 0;
  int nerr = 0;

  bit  cap [0:4095];
  int  ncap = 0;
  bit  cap_on = 1'b0;
  int  viol = 0;
  int  nrdy = 0;
  bit  rprev = 1'b0;

  logic [7:0] pay [0:1][0:63];
  logic [7:0] fb  [0:7][0:63];
  int         flen [0:7];
  int         fgap [0:7];
  int         nfr, nab;

  // Sample 5 ns after the rising edge, away from both edges.
  always @(posedge clk) begin
    #5;
    if (cap_on) begin
      if (ncap < 4096) begin
        cap[ncap] = txs;
        ncap++;
      end
      if (rdy && rprev) viol++;
      if (rdy) nrdy++;
      rprev = rdy;
    end else begin
      rprev = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int slot, input int n, input int w);
    logic [31:0] c, poly, mask;
    bit f;
    mask = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    poly = (w == 32) ? 32'hEDB8_8320 : 32'h0000_8408;
    c = mask;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        f = c[0] ^ pay[slot][i][b];
        c = c >> 1;
        if (f) c = c ^ poly;
      end
    end
    return ~c & mask;
  endfunction

  // Independent receiver: flag hunt, zero removal, abort detection.
  task automatic decode();
    int  ones = 0;
    bit  hunt = 1'b1;
    bit  bits [0:1023];
    int  nb = 0;
    int  gap = 0;
    int  nby;
    nfr = 0;
    nab = 0;
    for (int i = 0; i < ncap; i++) begin
      if (cap[i]) begin
        ones++;
        if (ones == 7 && !hunt) begin
          nab++;
          hunt = 1'b1;
          nb = 0;
        end else if (!hunt && nb < 1024) begin
          bits[nb] = 1'b1;
          nb++;
        end
      end else begin
        if (ones == 6) begin
          if (!hunt) begin
            if (nb == 7) begin
              gap++;
            end else if (nb > 7 && ((nb - 7) % 8) == 0 && nfr < 8) begin
              nby = (nb - 7) / 8;
              if (nby > 64) nby = 64;
              for (int k = 0; k < nby; k++)
                for (int b = 0; b < 8; b++)
                  fb[nfr][k][b] = bits[k*8 + b];
              flen[nfr] = nby;
              fgap[nfr] = gap;
              nfr++;
              gap = 0;
            end
          end
          hunt = 1'b0;
          nb = 0;
        end else if (ones == 5 || ones >= 7) begin
          // stuffed zero, or the zero ending an abort run
        end else if (!hunt && nb < 1024) begin
          bits[nb] = 1'b0;
          nb++;
        end
        ones = 0;
      end
    end
  endtask

  task automatic push(input logic [7:0] b, input bit last);
    @(negedge clk);
    v = 1'b1; d = b; l = last;
    #1;
    while (!rdy) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic send_frame(input int slot, input int n);
    for (int i = 0; i < n; i++) push(pay[slot][i], i == n - 1);
    @(negedge clk);
    v = 1'b0; l = 1'b0;
  endtask

  task automatic cap_start();
    @(negedge clk);
    ncap = 0;
    cap_on = 1'b1;
  endtask

  task automatic cap_stop(input int wait_cycles);
    repeat (wait_cycles) @(negedge clk);
    cap_on = 1'b0;
    decode();
  endtask

  task automatic check_frame(input int idx, input int slot, input int n, input int w, input string req);
    logic [31:0] ef, af;
    int fbytes;
    fbytes = w / 8;
    chk(flen[idx] == n + fbytes, req, flen[idx], n + fbytes);
    for (int i = 0; i < n; i++)
      chk(fb[idx][i] == pay[slot][i], req, fb[idx][i], pay[slot][i]);
    ef = fcs_of(slot, n, w);
    af = '0;
    for (int k = 0; k < fbytes; k++) af = af | (32'(fb[idx][n + k]) << (8 * k));
    chk(af == ef, req, af, ef);
  endtask

  task automatic load_ascii(input int slot);
    for (int i = 0; i < 9; i++) pay[slot][i] = 8'h31 + 8'(i);
  endtask

  // R11 reset state, then R1/R7 flag idle fill right after reset.
  task automatic t_reset();
    logic [15:0] got;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(tx0 == 1'b1, "R11 tx_bit in reset", tx0, 1);
    chk(rdy0 == 1'b0, "R11 in_ready in reset", rdy0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ncap = 0;
    cap_on = 1'b1;
    repeat (16) @(negedge clk);
    cap_on = 1'b0;
    got = '0;
    for (int i = 0; i < 16; i++) got[i] = cap[i];
    chk(got == 16'h7E7E, "R1 R7 idle flags after reset", got, 16'h7E7E);
    chk(nrdy == 0, "R10 ready low in idle", nrdy, 0);
  endtask

  task automatic t_basic();
    load_ascii(0);
    cap_start();
    send_frame(0, 9);
    cap_stop(60);
    chk(nfr == 1, "R1 one framed block", nfr, 1);
    check_frame(0, 0, 9, 16, "R2 R4 payload and FCS");
    chk({fb[0][10], fb[0][9]} == 16'h906E, "R4 check value", {fb[0][10], fb[0][9]}, 16'h906E);
  endtask

  task automatic t_stuff();
    pay[0][0] = 8'hFF; pay[0][1] = 8'hFF; pay[0][2] = 8'h7E;
    pay[0][3] = 8'h3E; pay[0][4] = 8'hF8; pay[0][5] = 8'h1F;
    pay[0][6] = 8'hFF;
    cap_start();
    send_frame(0, 7);
    cap_stop(70);
    chk(nfr == 1, "R3 stuffed frame decoded", nfr, 1);
    chk(nab == 0, "R3 no abort run inside frame", nab, 0);
    check_frame(0, 0, 7, 16, "R3 destuffed content");
  endtask

  task automatic t_shared();
    for (int i = 0; i < 5; i++) pay[0][i] = 8'hA0 + 8'(i);
    for (int i = 0; i < 4; i++) pay[1][i] = 8'h5C ^ 8'(i * 37);
    cap_start();
    send_frame(0, 5);
    send_frame(1, 4);
    cap_stop(60);
    chk(nfr == 2, "R6 two frames", nfr, 2);
    chk(fgap[1] == 0, "R6 single shared flag", fgap[1], 0);
    check_frame(0, 0, 5, 16, "R6 first frame");
    check_frame(1, 1, 4, 16, "R6 second frame");
  endtask

  task automatic t_abort();
    for (int i = 0; i < 6; i++) pay[0][i] = 8'h11 * 8'(i + 1);
    for (int i = 0; i < 3; i++) pay[1][i] = 8'hC3 - 8'(i);
    cap_start();
    for (int i = 0; i < 3; i++) push(pay[0][i], 1'b0);
    @(negedge clk);
    ab = 1'b1; v = 1'b0;
    @(negedge clk);
    ab = 1'b0;
    repeat (20) @(negedge clk);
    send_frame(1, 3);
    cap_stop(60);
    chk(nab == 1, "R8 abort run seen", nab, 1);
    chk(nfr == 1, "R8 aborted frame not closed", nfr, 1);
    check_frame(0, 1, 3, 16, "R8 frame after abort");
  endtask

  task automatic t_underrun();
    pay[0][0] = 8'h42; pay[0][1] = 8'h24;
    for (int i = 0; i < 2; i++) pay[1][i] = 8'h99 + 8'(i);
    cap_start();
    push(pay[0][0], 1'b0);
    push(pay[0][1], 1'b0);
    @(negedge clk);
    v = 1'b0;
    repeat (30) @(negedge clk);
    send_frame(1, 2);
    cap_stop(60);
    chk(nab == 1, "R9 underrun aborts", nab, 1);
    chk(nfr == 1, "R9 only later frame closed", nfr, 1);
    check_frame(0, 1, 2, 16, "R9 frame after underrun");
  endtask

  task automatic t_idle_ones();
    int ones;
    int r0;
    @(negedge clk);
    idlef = 1'b0;
    repeat (3) @(negedge clk);
    r0 = nrdy;
    cap_start();
    repeat (40) @(negedge clk);
    cap_on = 1'b0;
    ones = 0;
    for (int i = 0; i < 40; i++) ones += int'(cap[i]);
    chk(ones == 40, "R7 all-ones idle", ones, 40);
    chk(nrdy == r0, "R10 ready low in ones idle", nrdy, r0);
    pay[0][0] = 8'hE7; pay[0][1] = 8'h00; pay[0][2] = 8'hFE;
    cap_start();
    send_frame(0, 3);
    cap_stop(60);
    chk(nfr == 1, "R1 frame opened from ones idle", nfr, 1);
    check_frame(0, 0, 3, 16, "R1 content after ones idle");
    @(negedge clk);
    idlef = 1'b1;
  endtask

  task automatic t_crc32();
    load_ascii(0);
    @(negedge clk);
    sel = 1'b1;
    repeat (10) @(negedge clk);
    cap_start();
    send_frame(0, 9);
    cap_stop(80);
    chk(nfr == 1, "R5 frame with long FCS", nfr, 1);
    check_frame(0, 0, 9, 32, "R5 payload and FCS");
    chk({fb[0][12], fb[0][11], fb[0][10], fb[0][9]} == 32'hCBF43926, "R5 check value",
        {fb[0][12], fb[0][11], fb[0][10], fb[0][9]}, 32'hCBF43926);
    @(negedge clk);
    sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stuff();
    t_shared();
    t_abort();
    t_underrun();
    t_idle_ones();
    t_crc32();
    chk(viol == 0, "R10 ready never two cycles in a row", viol, 0);
    chk(nrdy > 0, "R2 ready seen during frames", nrdy, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule